// File: doc/BRIEF.md
# Sectioned Register Access Controller

This block sits behind a byte-level serial slave and owns a 64-location control and clock register space. The slave front end reports start and stop events, hands over each received byte, and asks for each byte it must transmit. The controller checks the device select byte and loads the address pointer. It steps the pointer through the space, holding it inside the section in use. It serves reads and collects write data in a staging buffer.

The space holds five sections: two 8-byte alarm blocks, a 4-byte control block, an 8-byte clock block and a single status byte. Staged data reaches the register array only when a stop closes the transfer. Writes to any section other than status also need a two-step unlock, done through the status byte. A transfer that a repeated start cuts short leaves no trace. A one-cycle commit pulse tells the downstream write engine that a section has been updated.

Top module: `sect_reg_ctrl`

## Requirements
- R1: After reset every defined location reads 0x00, undefined locations read 0x00, and the status byte reads 0x01 (only the clock-fail flag set) while the three flag inputs are low.
- R2: The first byte after a start selects the block only when its bits 7..1 equal 1101111. Bit 0 = 1 means read and bit 0 = 0 means write. Any other value makes the block ignore all bytes until the next start, and read requests then return 0xFF.
- R3: In a write, the two bytes after the select byte form the address. The first is ignored and bits 5..0 of the second load the pointer.
- R4: Section map: alarm 0 at 0x00-0x07, alarm 1 at 0x08-0x0F, control at 0x10-0x13, clock at 0x30-0x37, status at 0x3F. Reading or writing past a section's last byte wraps to that section's first byte.
- R5: Undefined addresses read 0x00 and drop writes, and the pointer advances from them by one modulo 64.
- R6: The status byte takes one byte per transfer. After one status byte, further reads return 0xFF and further write bytes are ignored until the next start.
- R7: The status byte reads as {battery, alarm1, alarm0, 0, 0, RWEL, WEL, clock-fail} from bit 7 down to bit 0.
- R8: A status write takes effect at stop. WEL takes bit 1 of the written byte. RWEL is set only when the byte is 0x06 and WEL was already set; any other status write clears RWEL.
- R9: Staged data for alarm, control or clock sections is committed at stop only when WEL and RWEL are both set; otherwise it is dropped.
- R10: Staged write data is discarded when a start arrives before a stop.
- R11: After a read or write the pointer holds the address after the last byte accessed (wrapped per R4), so a read with no address phase continues from there.
- R12: commit_o is high for exactly the one cycle after a stop that commits data to a non-status section.
- R13: A committed write to the clock section clears the clock-fail flag; nothing else sets it except reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start or repeated-start event, one cycle |
| stop_i | input | 1 | Stop event, one cycle |
| byte_valid_i | input | 1 | A received byte is on byte_i |
| byte_i | input | 8 | Received byte |
| rd_req_i | input | 1 | Front end needs the next byte to transmit |
| bat_i | input | 1 | Running-on-battery flag for status bit 7 |
| al1_i | input | 1 | Alarm 1 match flag for status bit 6 |
| al0_i | input | 1 | Alarm 0 match flag for status bit 5 |
| rd_data_o | output | 8 | Byte to transmit, valid with rd_valid_o |
| rd_valid_o | output | 1 | One cycle after rd_req_i, rd_data_o is valid |
| commit_o | output | 1 | One-cycle pulse after a committing stop |

## Verification
A wrong pointer or section decode shows on the very next read byte: a burst that leaves its section returns data from a neighbouring block instead of wrapping. The bench sweeps every start offset of every section with bursts longer than the section. A wrong unlock state shows only at the next stop, as a missing or extra commit pulse, and at the next status read. So each unlock step is followed by a write attempt and a status read-back. Staging faults remain hidden until the stop after the faulty transfer and show there as stale data, so every write is read back in the following transfer.

// File: rtl/rac_pkg.sv
// Shared types and section decode for the sectioned register access controller.
// Assumes a 6-bit register address space with sections aligned to their size.
package rac_pkg;
    localparam int AW = 6;
    localparam int DW = 8;
    localparam int STAGE_DEPTH = 8;

    typedef enum logic [2:0] {
        SEC_AL0, SEC_AL1, SEC_CTL, SEC_CLK, SEC_STS, SEC_NONE
    } rac_sec_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DEV, ST_ADH, ST_ADL, ST_WR, ST_RD, ST_SKIP
    } rac_state_e;

    // Map an address to the section holding it.
    function automatic rac_sec_e rac_sec_of(input logic [AW-1:0] a);
        if (a[5:3] == 3'b000)      return SEC_AL0;
        else if (a[5:3] == 3'b001) return SEC_AL1;
        else if (a[5:2] == 4'b0100) return SEC_CTL;
        else if (a[5:3] == 3'b110) return SEC_CLK;
        else if (a == 6'h3F)       return SEC_STS;
        else                       return SEC_NONE;
    endfunction

    // Offset bits that wrap within a section (size - 1).
    function automatic logic [AW-1:0] rac_off_mask(input rac_sec_e s);
        case (s)
            SEC_AL0, SEC_AL1, SEC_CLK: return 6'h07;
            SEC_CTL:                   return 6'h03;
            SEC_STS:                   return 6'h00;
            default:                   return 6'h3F;
        endcase
    endfunction
endpackage

// File: rtl/rac_decode.sv
// Section decoder and in-section pointer increment.
// Assumes each section is a power-of-two size aligned to its size.
module rac_decode
    import rac_pkg::*;
(
    input  logic [AW-1:0] addr_i,
    output rac_sec_e      sec_o,
    output logic [AW-1:0] next_o
);
    logic [AW-1:0] mask;

    // Decode the section and form the wrapped next address.
    always_comb begin
        sec_o  = rac_sec_of(addr_i);
        mask   = rac_off_mask(sec_o);
        next_o = (addr_i & ~mask) | ((addr_i + AW'(1)) & mask);
    end
endmodule

// File: rtl/rac_stage.sv
// Write staging buffer: one byte per section offset plus a written-mask.
// Assumes clear has priority over a write in the same cycle.
module rac_stage #(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clear_i,
    input  logic                        we_i,
    input  logic [IW-1:0]               idx_i,
    input  logic [DW-1:0]               din_i,
    output logic [DEPTH-1:0][DW-1:0]    data_o,
    output logic [DEPTH-1:0]            mask_o
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        // Hold one staged byte and whether it was written.
        always_ff @(posedge clk) begin
            if (!rst_n || clear_i) begin
                mask_o[g] <= 1'b0;
                data_o[g] <= '0;
            end else if (we_i && idx_i == IW'(g)) begin
                mask_o[g] <= 1'b1;
                data_o[g] <= din_i;
            end
        end
    end
endmodule

// File: rtl/rac_unlock.sv
// Write-enable latch pair and clock-fail flag of the status byte.
// Assumes sts_we_i pulses only on a stop that closes a status write.
module rac_unlock (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sts_we_i,
    input  logic [7:0] sts_din_i,
    input  logic       clk_commit_i,
    output logic       wel_o,
    output logic       rwel_o,
    output logic       rtcf_o
);
    // Two-step unlock: the second step counts only if the first is in place.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_o  <= 1'b0;
            rwel_o <= 1'b0;
        end else if (sts_we_i) begin
            wel_o  <= sts_din_i[1];
            rwel_o <= (sts_din_i == 8'h06) && wel_o;
        end
    end

    // Clock-fail flag: set by reset, cleared by a committed clock write.
    always_ff @(posedge clk) begin
        if (!rst_n)            rtcf_o <= 1'b1;
        else if (clk_commit_i) rtcf_o <= 1'b0;
    end
endmodule

// File: rtl/sect_reg_ctrl.sv
// Top: transfer sequencer, section-wrapping pointer, register array and
// commit logic. Assumes start/stop/byte/read-request events are one-cycle
// pulses from a byte-level serial front end, at most one kind per cycle.
module sect_reg_ctrl
    import rac_pkg::*;
#(
    parameter logic [6:0] DEV_ID = 7'b1101111
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          byte_valid_i,
    input  logic [DW-1:0] byte_i,
    input  logic          rd_req_i,
    input  logic          bat_i,
    input  logic          al1_i,
    input  logic          al0_i,
    output logic [DW-1:0] rd_data_o,
    output logic          rd_valid_o,
    output logic          commit_o
);
    localparam int NLOC = 1 << AW;
    localparam int IW   = $clog2(STAGE_DEPTH);

    rac_state_e    state_q;
    logic [AW-1:0] ptr_q;
    rac_sec_e      wsec_q;
    logic [AW-1:IW] wblk_q;
    logic [DW-1:0] mem [NLOC];

    rac_sec_e      ptr_sec;
    logic [AW-1:0] ptr_next;
    logic [STAGE_DEPTH-1:0][DW-1:0] stage_data;
    logic [STAGE_DEPTH-1:0]         stage_mask;
    logic          wel_w, rwel_w, rtcf_w;
    logic          stage_we, commit_ok, sts_we, clk_commit;
    logic [DW-1:0] status_byte, cur_byte;

    rac_decode u_dec (
        .addr_i (ptr_q),
        .sec_o  (ptr_sec),
        .next_o (ptr_next)
    );

    rac_stage #(.DW(DW), .DEPTH(STAGE_DEPTH)) u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (start_i || stop_i),
        .we_i    (stage_we),
        .idx_i   (ptr_q[IW-1:0]),
        .din_i   (byte_i),
        .data_o  (stage_data),
        .mask_o  (stage_mask)
    );

    rac_unlock u_unl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sts_we_i     (sts_we),
        .sts_din_i    (stage_data[STAGE_DEPTH-1]),
        .clk_commit_i (clk_commit),
        .wel_o        (wel_w),
        .rwel_o       (rwel_w),
        .rtcf_o       (rtcf_w)
    );

    // Event qualification: staging, status update and section commit.
    always_comb begin
        stage_we   = byte_valid_i && !start_i && !stop_i &&
                     state_q == ST_WR && wsec_q != SEC_NONE;
        commit_ok  = stop_i && (|stage_mask) && wel_w && rwel_w &&
                     wsec_q != SEC_NONE && wsec_q != SEC_STS;
        sts_we     = stop_i && (|stage_mask) && wsec_q == SEC_STS;
        clk_commit = commit_ok && wsec_q == SEC_CLK;
    end

    // Byte presented for the current pointer.
    always_comb begin
        status_byte = {bat_i, al1_i, al0_i, 2'b00, rwel_w, wel_w, rtcf_w};
        case (ptr_sec)
            SEC_NONE: cur_byte = '0;
            SEC_STS:  cur_byte = status_byte;
            default:  cur_byte = mem[ptr_q];
        endcase
    end

    // Transfer sequencer, pointer and read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            ptr_q      <= '0;
            wsec_q     <= SEC_NONE;
            wblk_q     <= '0;
            rd_data_o  <= '0;
            rd_valid_o <= 1'b0;
            commit_o   <= 1'b0;
        end else begin
            rd_valid_o <= 1'b0;
            commit_o   <= commit_ok;
            if (start_i) begin
                state_q <= ST_DEV;
            end else if (stop_i) begin
                state_q <= ST_IDLE;
            end else if (byte_valid_i) begin
                case (state_q)
                    ST_DEV: begin
                        if (byte_i[7:1] != DEV_ID) state_q <= ST_SKIP;
                        else if (byte_i[0])       state_q <= ST_RD;
                        else                      state_q <= ST_ADH;
                    end
                    ST_ADH: state_q <= ST_ADL;
                    ST_ADL: begin
                        ptr_q   <= byte_i[AW-1:0];
                        wsec_q  <= rac_sec_of(byte_i[AW-1:0]);
                        wblk_q  <= byte_i[AW-1:IW];
                        state_q <= ST_WR;
                    end
                    ST_WR: begin
                        ptr_q <= ptr_next;
                        if (wsec_q == SEC_STS) state_q <= ST_SKIP;
                    end
                    default: ;
                endcase
            end
            if (rd_req_i && !start_i && !stop_i) begin
                rd_valid_o <= 1'b1;
                if (state_q == ST_RD) begin
                    rd_data_o <= cur_byte;
                    ptr_q     <= ptr_next;
                    if (ptr_sec == SEC_STS) state_q <= ST_SKIP;
                end else begin
                    rd_data_o <= '1;
                end
            end
        end
    end

    // Register array: staged bytes land in their section at a qualified stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NLOC; i++) mem[i] <= '0;
        end else if (commit_ok) begin
            for (int i = 0; i < STAGE_DEPTH; i++)
                if (stage_mask[i]) mem[{wblk_q, IW'(i)}] <= stage_data[i];
        end
    end
endmodule

// File: rtl/rac_checker.sv
// Temporal checks on the controller, bound into every instance.
// Assumes the internal names of sect_reg_ctrl at the bind point.
module rac_checker
    import rac_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          stop_i,
    input logic          byte_valid_i,
    input logic          rd_req_i,
    input logic          rd_valid_o,
    input logic [DW-1:0] rd_data_o,
    input logic          commit_o,
    input logic          wel,
    input logic          rwel,
    input logic          rtcf,
    input rac_state_e    state,
    input rac_sec_e      wsec,
    input logic [AW-1:0] ptr
);
    // R12: commit pulse lasts one cycle and follows a stop.
    a_r12_commit_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> !commit_o);
    a_r12_commit_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> $past(stop_i));
    // R9: a commit only happens while both enables were set.
    a_r9_commit_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> $past(wel && rwel));
    // R8: RWEL can only rise on a stop while WEL was already set.
    a_r8_rwel_after_wel: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rwel) |-> $past(wel && stop_i));
    // R13: the clock-fail flag never rises outside reset.
    a_r13_rtcf_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(rtcf));
    // R6: a read request after the transfer ended returns all ones.
    a_r6_ended_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_i && !start_i && !stop_i && state == ST_SKIP) |=>
        (rd_valid_o && rd_data_o == 8'hFF));
    // R4: a data byte never moves the pointer out of its section.
    a_r4_ptr_stays_in_section: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR && byte_valid_i && !start_i && !stop_i &&
         wsec != SEC_NONE) |=> (rac_sec_of(ptr) == wsec));
endmodule

bind sect_reg_ctrl rac_checker u_rac_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .byte_valid_i (byte_valid_i),
    .rd_req_i     (rd_req_i),
    .rd_valid_o   (rd_valid_o),
    .rd_data_o    (rd_data_o),
    .commit_o     (commit_o),
    .wel          (wel_w),
    .rwel         (rwel_w),
    .rtcf         (rtcf_w),
    .state        (state_q),
    .wsec         (wsec_q),
    .ptr          (ptr_q)
);

// File: tb/sim_sect_reg_ctrl.sv
module sim_sect_reg_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 0, stop_i = 0, byte_valid_i = 0, rd_req_i = 0;
    logic [7:0] byte_i = 0;
    logic bat_i = 0, al1_i = 0, al0_i = 0;
    logic [7:0] rd_data_o;
    logic rd_valid_o, commit_o;

    int tests = 0, fails = 0;
    logic [7:0] m [64];
    bit wel = 0, rwel = 0, rtcf = 1;
    bit last_commit;

    always #2 clk = ~clk;

    sect_reg_ctrl u0 (.*);

    // Bench model of the section map (R4, R5).
    function automatic int fsize(int a);
        if (a < 16) return 8;
        if (a >= 16 && a < 20) return 4;
        if (a >= 48 && a < 56) return 8;
        if (a == 63) return 1;
        return 0;
    endfunction
    function automatic int fbase(int a);
        if (a == 63) return 63;
        if (fsize(a) == 4) return 16;
        return a - (a % 8);
    endfunction
    function automatic int fnext(int a);
        if (fsize(a) == 0) return (a + 1) % 64;
        return fbase(a) + ((a - fbase(a) + 1) % fsize(a));
    endfunction
    function automatic logic [7:0] stat_exp();
        return {bat_i, al1_i, al0_i, 2'b00, rwel, wel, rtcf};
    endfunction
    function automatic logic [7:0] fexp(int a);
        if (a == 63) return stat_exp();
        if (fsize(a) == 0) return 8'h00;
        return m[a];
    endfunction

    task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", r, act, exp);
        end
    endtask

    task automatic ev_start();
        @(negedge clk) start_i = 1;
        @(negedge clk) start_i = 0;
    endtask
    task automatic ev_stop();
        @(negedge clk) stop_i = 1;
        @(negedge clk) stop_i = 0;
        last_commit = commit_o;
    endtask
    task automatic put(input logic [7:0] b);
        @(negedge clk) begin byte_i = b; byte_valid_i = 1; end
        @(negedge clk) byte_valid_i = 0;
    endtask
    task automatic get(output logic [7:0] d);
        @(negedge clk) rd_req_i = 1;
        @(negedge clk) rd_req_i = 0;
        d = rd_data_o;
    endtask
    task automatic set_ptr(input int a);
        ev_start(); put(8'hDE); put(8'h00); put(8'(a));
    endtask
    task automatic rd_at(input int a, output logic [7:0] d);
        set_ptr(a); ev_start(); put(8'hDF); get(d); ev_stop();
    endtask
    task automatic sts_wr(input logic [7:0] v);
        set_ptr(63); put(v); ev_stop();
        rwel = (v == 8'h06) && wel;
        wel = v[1];
    endtask
    task automatic wr_burst(input int a, input int n, input int seed);
        bit ok;
        int p;
        ok = wel && rwel && fsize(a) > 0 && a != 63 && n > 0;
        set_ptr(a);
        for (int k = 0; k < n; k++) put(8'(seed + k));
        ev_stop();
        chk(ok ? "R12 commit pulse" : "R9 no commit when locked", 8'(last_commit), 8'(ok));
        if (ok) begin
            p = a;
            for (int k = 0; k < n; k++) begin m[p] = 8'(seed + k); p = fnext(p); end
            if (a >= 48 && a < 56) rtcf = 0;
        end
    endtask

    logic [7:0] d;

    initial begin
        for (int i = 0; i < 64; i++) m[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1;

        // R1: reset contents over the whole space
        for (int a = 0; a < 64; a++) begin
            rd_at(a, d); chk("R1 reset value", d, fexp(a));
        end

        // R9: locked write is dropped
        wr_burst(2, 3, 8'h11);
        rd_at(2, d); chk("R9 locked write dropped", d, fexp(2));

        // R8: 0x06 without WEL only sets WEL
        sts_wr(8'h06); rd_at(63, d); chk("R8 first step", d, stat_exp());
        wr_burst(16, 1, 8'h20);
        sts_wr(8'h00); rd_at(63, d); chk("R8 clear WEL", d, stat_exp());
        sts_wr(8'h02); rd_at(63, d); chk("R8 set WEL", d, stat_exp());
        sts_wr(8'h06); rd_at(63, d); chk("R8 set RWEL", d, stat_exp());

        // R4 R11 R12: every start offset of every section, bursts that wrap
        for (int s = 0; s < 4; s++) begin
            int base, sz;
            base = (s == 0) ? 0 : (s == 1) ? 8 : (s == 2) ? 16 : 48;
            sz = fsize(base);
            for (int o = 0; o < sz; o++) begin
                int p;
                wr_burst(base + o, sz + 2, 16 * s + 3 * o + 1);
                set_ptr(base + o); ev_start(); put(8'hDF);
                p = base + o;
                for (int k = 0; k <= sz; k++) begin
                    get(d); chk("R4 wrap read", d, fexp(p)); p = fnext(p);
                end
                ev_stop();
                ev_start(); put(8'hDF); get(d); ev_stop();
                chk("R11 current address read", d, fexp(p));
            end
        end

        // R13: clock commits cleared the clock-fail flag
        rd_at(63, d); chk("R13 clock-fail cleared", d, stat_exp());

        // R10: repeated start discards staged byte
        set_ptr(8); put(8'hAA); ev_start(); put(8'hDF); get(d);
        chk("R10 read after abort", d, fexp(9));
        ev_stop();
        rd_at(8, d); chk("R10 aborted write discarded", d, fexp(8));

        // R6: single byte status write and read
        set_ptr(63); put(8'h02); put(8'h00); put(8'h06); ev_stop();
        rwel = 0; wel = 1;
        set_ptr(63); ev_start(); put(8'hDF);
        get(d); chk("R6 status first byte", d, stat_exp());
        get(d); chk("R6 status second byte", d, 8'hFF);
        ev_stop();
        sts_wr(8'h06);

        // R8: any other pattern clears RWEL, then writes are dropped
        sts_wr(8'h03); rd_at(63, d); chk("R8 other pattern", d, stat_exp());
        wr_burst(17, 1, 8'h5C);
        rd_at(17, d); chk("R9 dropped after relock", d, fexp(17));
        sts_wr(8'h02); sts_wr(8'h06);

        // R5: undefined addresses
        wr_burst(32, 2, 8'h77);
        rd_at(32, d); chk("R5 undefined reads zero", d, 8'h00);
        set_ptr(47); ev_start(); put(8'hDF);
        get(d); chk("R5 undefined 0x2F", d, 8'h00);
        get(d); chk("R5 linear step to 0x30", d, fexp(48));
        ev_stop();

        // R2: wrong device byte
        ev_start(); put(8'hA0); put(8'h00); put(8'h00); put(8'h55);
        get(d); chk("R2 unselected read", d, 8'hFF);
        ev_stop(); chk("R2 no commit", 8'(last_commit), 8'h00);
        rd_at(0, d); chk("R2 unselected write ignored", d, fexp(0));

        // R3: high address byte ignored
        ev_start(); put(8'hDE); put(8'h5A); put(8'h11); put(8'h3C); ev_stop();
        m[17] = 8'h3C;
        rd_at(17, d); chk("R3 high address ignored", d, fexp(17));

        // R7: flag inputs in every combination
        for (int f = 0; f < 8; f++) begin
            {bat_i, al1_i, al0_i} = 3'(f);
            rd_at(63, d); chk("R7 status layout", d, stat_exp());
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #800000;
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule